// File: doc/BRIEF.md
# Frame/Element DMA Channel Sequencer

This block is the engine of one DMA channel. A control packet is loaded into it through a set of configuration inputs and a one-cycle load strobe. The packet gives the starting source and destination addresses, the number of elements in a frame, the number of frames in the block, per-element and per-frame byte offsets for each side, separate read and write access sizes, the transfer type, the addressing mode of each side and an automatic-reload flag. When a trigger arrives, the engine reads elements through a request/valid read port and writes them through a request/acknowledge write port, moving the addresses after each access.

A trigger is either a hardware request or a software request, as the channel is set up. In frame mode one trigger moves a whole frame. In element mode it moves a single element. A trigger that arrives while a unit is still moving is held and served as soon as that unit ends. When the last write of the block is acknowledged, the engine pulses a done flag. It then either reloads the packet and waits for the next trigger, or disarms until a new packet is loaded.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, rd_req, wr_req, busy and block_done are all 0, and the channel is disarmed, so triggers have no effect until a packet is loaded.
- R2: A cfg_load pulse seen while the engine is idle captures every cfg_* field and arms the channel. A cfg_load pulse during a transfer is ignored, and the transfer and the rest of the block keep the addresses of the packet already captured.
- R3: A trigger is counted only when chan_en is 1. With hw_sel=1 only hw_req counts, and with hw_sel=0 only sw_req counts. Every other request pulse leaves busy at 0 and issues no read.
- R4: cfg_frame_mode=1 makes each trigger move one whole frame of elements. cfg_frame_mode=0 makes each trigger move exactly one element.
- R5: One block moves elem_cnt times frame_cnt elements. An element count or frame count of 0 is treated as 1.
- R6: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Each element is one read of rd_size. It is written as 2^(rd_size-wr_size) writes of wr_size, lowest-addressed lane first, with the lane in the low bits of wr_data and the upper bits zero. A write size larger than the read size is used as the read size.
- R7: With the offset mode bit of a side at 1, that side's address grows after each of its accesses by the signed 16-bit element offset. After the access that ends a frame (the last read of the frame for the source, the last write of the frame for the destination) it grows by the frame offset instead. With the mode bit at 0 the address stays fixed.
- R8: rd_req holds with a stable rd_addr until rd_valid. wr_req holds with stable wr_addr and wr_data until wr_ack. rd_req and wr_req are never high together, and a new read waits until all writes of the previous element are acknowledged.
- R9: block_done is high for exactly one cycle: the cycle after the acknowledge of the block's last write.
- R10: A trigger that arrives while a unit is in progress is held, one deep, and the next unit starts right after the current one with no further trigger.
- R11: With cfg_auto_reload=1 the block end restores the initial addresses and counts and keeps the channel armed. With it at 0 the channel disarms, drops any held trigger and ignores triggers until the next cfg_load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load strobe for the control packet |
| cfg_src_base | input | ADDR_W | Initial source byte address |
| cfg_dst_base | input | ADDR_W | Initial destination byte address |
| cfg_elem_cnt | input | CNT_W | Elements per frame |
| cfg_frame_cnt | input | CNT_W | Frames per block |
| cfg_src_elem_step | input | OFS_W | Signed source offset after an element |
| cfg_src_frame_step | input | OFS_W | Signed source offset after a frame |
| cfg_dst_elem_step | input | OFS_W | Signed destination offset after a write |
| cfg_dst_frame_step | input | OFS_W | Signed destination offset after a frame |
| cfg_rd_size | input | 2 | Read size code |
| cfg_wr_size | input | 2 | Write size code |
| cfg_frame_mode | input | 1 | 1: frame per trigger, 0: element per trigger |
| cfg_src_offset_mode | input | 1 | Source addressing: 1 offset, 0 fixed |
| cfg_dst_offset_mode | input | 1 | Destination addressing: 1 offset, 0 fixed |
| cfg_auto_reload | input | 1 | Reload and stay armed after the block |
| chan_en | input | 1 | Channel enable |
| hw_sel | input | 1 | 1: hardware trigger, 0: software trigger |
| hw_req | input | 1 | Hardware request pulse |
| sw_req | input | 1 | Software request pulse |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_size | output | 2 | Read size code |
| rd_valid | input | 1 | Read data valid, ends the read |
| rd_data | input | 64 | Read data, low-aligned |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write byte address |
| wr_size | output | 2 | Write size code |
| wr_data | output | 64 | Write data, low-aligned |
| wr_ack | input | 1 | Write acknowledge |
| busy | output | 1 | Engine is moving a unit |
| block_done | output | 1 | One-cycle end-of-block pulse |

## Verification
The bench uses the default parameters: 32-bit addresses, 13-bit counts and 16-bit signed offsets. This is enough for offsets that step backwards and for the zero-count case. Every pairing of read and write size is reachable, from one lane per element up to eight byte-wide writes per 64-bit read. The memory responders add random delays of zero to two cycles. These make the hold-until-handshake rules and the held-trigger path visible at realistic spacings.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;

  localparam int BEAT_BITS = 64;
  typedef logic [BEAT_BITS-1:0] beat_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [1:0] rd_size;
    logic [1:0] wr_size;
    logic       frame_mode;
    logic       src_ofs_mode;
    logic       dst_ofs_mode;
    logic       auto_reload;
  } chan_mode_t;

  // write size actually used: never wider than the read
  function automatic logic [1:0] eff_wr_size(logic [1:0] rs, logic [1:0] ws);
    return (ws > rs) ? rs : ws;
  endfunction

  // number of writes per element, minus one
  function automatic logic [2:0] last_lane(logic [1:0] rs, logic [1:0] ws);
    logic [1:0] d;
    d = rs - eff_wr_size(rs, ws);
    case (d)
      2'd0:    return 3'd0;
      2'd1:    return 3'd1;
      2'd2:    return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

  // lane idx of width ws, moved down to bit 0, upper bits cleared
  function automatic beat_t pick_lane(beat_t b, logic [2:0] idx, logic [1:0] ws);
    logic [5:0] sh;
    beat_t      m;
    case (ws)
      2'd0:    begin sh = {idx, 3'b000};         m = 64'h0000_0000_0000_00FF; end
      2'd1:    begin sh = {idx[1:0], 4'b0000};   m = 64'h0000_0000_0000_FFFF; end
      2'd2:    begin sh = {idx[0], 5'b00000};    m = 64'h0000_0000_FFFF_FFFF; end
      default: begin sh = 6'd0;                  m = '1; end
    endcase
    return (b >> sh) & m;
  endfunction

endpackage

// File: rtl/dma_seq_trig.sv
`timescale 1ns/1ps
module dma_seq_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic hw_sel,
  input  logic hw_req,
  input  logic sw_req,
  input  logic armed,
  input  logic idle,
  input  logic consume,
  input  logic drop,
  output logic trig,
  output logic pending
);

  assign trig = chan_en & armed & (hw_sel ? hw_req : sw_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pending <= 1'b0;
    else if (drop)    pending <= 1'b0;
    else if (consume) pending <= pending & trig;
    else              pending <= pending | (trig & ~idle);
  end

  // held trigger never waits in idle (R10)
  assert_pending_not_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !idle);

  // a held trigger only appears after an accepted trigger (R3)
  assert_pending_from_trig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(trig));

endmodule

// File: rtl/dma_seq_addr.sv
`timescale 1ns/1ps
module dma_seq_addr #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic              step,
  input  logic              frame_end,
  input  logic              offset_mode,
  input  logic [OFS_W-1:0]  elem_ofs,
  input  logic [OFS_W-1:0]  frame_ofs,
  output logic [ADDR_W-1:0] addr
);

  localparam int EXT_W = ADDR_W - OFS_W;

  logic [OFS_W-1:0]  ofs_sel;
  logic [ADDR_W-1:0] ofs_ext;

  assign ofs_sel = frame_end ? frame_ofs : elem_ofs;
  assign ofs_ext = {{EXT_W{ofs_sel[OFS_W-1]}}, ofs_sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    addr <= '0;
    else if (load)                 addr <= init_addr;
    else if (step && offset_mode)  addr <= addr + ofs_ext;
  end

  // fixed addressing holds the address between loads (R7)
  assert_fixed_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !offset_mode) |=> $stable(addr));

endmodule

// File: rtl/dma_seq_count.sv
`timescale 1ns/1ps
module dma_seq_count #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] elem_init,
  input  logic [CNT_W-1:0] frame_init,
  input  logic             elem_done,
  output logic             last_elem,
  output logic             last_frame
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] elem_left;
  logic [CNT_W-1:0] frame_left;

  function automatic logic [CNT_W-1:0] at_least_one(logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  assign last_elem  = (elem_left == ONE);
  assign last_frame = (frame_left == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_left  <= ONE;
      frame_left <= ONE;
    end else if (load) begin
      elem_left  <= at_least_one(elem_init);
      frame_left <= at_least_one(frame_init);
    end else if (elem_done) begin
      if (last_elem) begin
        elem_left <= at_least_one(elem_init);
        if (!last_frame) frame_left <= frame_left - ONE;
      end else begin
        elem_left <= elem_left - ONE;
      end
    end
  end

  // remaining counts never reach zero (R5)
  assert_counts_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_left != '0) && (frame_left != '0));

endmodule

// File: rtl/dma_chan_seq.sv
`timescale 1ns/1ps
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 13,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_src_base,
  input  logic [ADDR_W-1:0] cfg_dst_base,
  input  logic [CNT_W-1:0]  cfg_elem_cnt,
  input  logic [CNT_W-1:0]  cfg_frame_cnt,
  input  logic [OFS_W-1:0]  cfg_src_elem_step,
  input  logic [OFS_W-1:0]  cfg_src_frame_step,
  input  logic [OFS_W-1:0]  cfg_dst_elem_step,
  input  logic [OFS_W-1:0]  cfg_dst_frame_step,
  input  logic [1:0]        cfg_rd_size,
  input  logic [1:0]        cfg_wr_size,
  input  logic              cfg_frame_mode,
  input  logic              cfg_src_offset_mode,
  input  logic              cfg_dst_offset_mode,
  input  logic              cfg_auto_reload,
  input  logic              chan_en,
  input  logic              hw_sel,
  input  logic              hw_req,
  input  logic              sw_req,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_size,
  input  logic              rd_valid,
  input  logic [63:0]       rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [1:0]        wr_size,
  output logic [63:0]       wr_data,
  input  logic              wr_ack,
  output logic              busy,
  output logic              block_done
);

  localparam int SIDES = 2;  // 0: source, 1: destination

  seq_state_e st;
  logic       armed;

  // captured packet
  logic [ADDR_W-1:0] snap_src, snap_dst;
  logic [CNT_W-1:0]  snap_ecnt, snap_fcnt;
  logic [OFS_W-1:0]  snap_seo, snap_sfo, snap_deo, snap_dfo;
  chan_mode_t        snap_mode, cfg_mode;

  beat_t      rdbuf;
  logic [2:0] lane;

  // named internal events
  logic take_pkt, trig, pending, launch;
  logic rd_fire, wr_fire, lane_last, elem_end, unit_end, block_end;
  logic last_elem, last_frame, disarm, serve, consume, reload, side_load;
  logic [1:0] eff_ws;

  assign cfg_mode = '{rd_size: cfg_rd_size, wr_size: cfg_wr_size,
                      frame_mode: cfg_frame_mode, src_ofs_mode: cfg_src_offset_mode,
                      dst_ofs_mode: cfg_dst_offset_mode, auto_reload: cfg_auto_reload};

  assign take_pkt  = cfg_load && (st == SEQ_IDLE);
  assign launch    = trig && (st == SEQ_IDLE);
  assign rd_fire   = (st == SEQ_READ) && rd_valid;
  assign wr_fire   = (st == SEQ_WRITE) && wr_ack;
  assign eff_ws    = eff_wr_size(snap_mode.rd_size, snap_mode.wr_size);
  assign lane_last = (lane == last_lane(snap_mode.rd_size, snap_mode.wr_size));
  assign elem_end  = wr_fire && lane_last;
  assign unit_end  = elem_end && (!snap_mode.frame_mode || last_elem);
  assign block_end = elem_end && last_elem && last_frame;
  assign reload    = block_end && snap_mode.auto_reload;
  assign disarm    = block_end && !snap_mode.auto_reload;
  assign serve     = pending || trig;
  assign consume   = unit_end && !disarm && serve;
  assign side_load = take_pkt || reload;

  dma_seq_trig u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .chan_en (chan_en),
    .hw_sel  (hw_sel),
    .hw_req  (hw_req),
    .sw_req  (sw_req),
    .armed   (armed),
    .idle    (st == SEQ_IDLE),
    .consume (consume),
    .drop    (disarm),
    .trig    (trig),
    .pending (pending)
  );

  dma_seq_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (side_load),
    .elem_init  (take_pkt ? cfg_elem_cnt  : snap_ecnt),
    .frame_init (take_pkt ? cfg_frame_cnt : snap_fcnt),
    .elem_done  (elem_end),
    .last_elem  (last_elem),
    .last_frame (last_frame)
  );

  // address generators, one per side
  logic [ADDR_W-1:0] side_init [SIDES];
  logic [ADDR_W-1:0] side_addr [SIDES];
  logic [OFS_W-1:0]  side_eofs [SIDES];
  logic [OFS_W-1:0]  side_fofs [SIDES];
  logic              side_step [SIDES];
  logic              side_fend [SIDES];
  logic              side_mode [SIDES];

  always_comb begin
    side_init[0] = take_pkt ? cfg_src_base : snap_src;
    side_init[1] = take_pkt ? cfg_dst_base : snap_dst;
    side_eofs[0] = snap_seo;
    side_fofs[0] = snap_sfo;
    side_eofs[1] = snap_deo;
    side_fofs[1] = snap_dfo;
    side_step[0] = rd_fire;
    side_step[1] = wr_fire;
    side_fend[0] = last_elem;
    side_fend[1] = last_elem && lane_last;
    side_mode[0] = snap_mode.src_ofs_mode;
    side_mode[1] = snap_mode.dst_ofs_mode;
  end

  genvar s;
  generate
    for (s = 0; s < SIDES; s++) begin : g_side
      dma_seq_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (side_load),
        .init_addr   (side_init[s]),
        .step        (side_step[s]),
        .frame_end   (side_fend[s]),
        .offset_mode (side_mode[s]),
        .elem_ofs    (side_eofs[s]),
        .frame_ofs   (side_fofs[s]),
        .addr        (side_addr[s])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= SEQ_IDLE;
      armed      <= 1'b0;
      snap_src   <= '0;
      snap_dst   <= '0;
      snap_ecnt  <= '0;
      snap_fcnt  <= '0;
      snap_seo   <= '0;
      snap_sfo   <= '0;
      snap_deo   <= '0;
      snap_dfo   <= '0;
      snap_mode  <= '0;
      rdbuf      <= '0;
      lane       <= '0;
      block_done <= 1'b0;
    end else begin
      block_done <= block_end;
      if (take_pkt) begin
        snap_src  <= cfg_src_base;
        snap_dst  <= cfg_dst_base;
        snap_ecnt <= cfg_elem_cnt;
        snap_fcnt <= cfg_frame_cnt;
        snap_seo  <= cfg_src_elem_step;
        snap_sfo  <= cfg_src_frame_step;
        snap_deo  <= cfg_dst_elem_step;
        snap_dfo  <= cfg_dst_frame_step;
        snap_mode <= cfg_mode;
        armed     <= 1'b1;
      end
      case (st)
        SEQ_IDLE: if (launch) st <= SEQ_READ;
        SEQ_READ: if (rd_valid) begin
          rdbuf <= rd_data;
          lane  <= '0;
          st    <= SEQ_WRITE;
        end
        SEQ_WRITE: if (wr_ack) begin
          if (!lane_last) begin
            lane <= lane + 3'd1;
          end else if (disarm) begin
            st    <= SEQ_IDLE;
            armed <= 1'b0;
          end else if (!unit_end || serve) begin
            st <= SEQ_READ;
          end else begin
            st <= SEQ_IDLE;
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  assign rd_req  = (st == SEQ_READ);
  assign rd_addr = side_addr[0];
  assign rd_size = snap_mode.rd_size;
  assign wr_req  = (st == SEQ_WRITE);
  assign wr_addr = side_addr[1];
  assign wr_size = eff_ws;
  assign wr_data = pick_lane(rdbuf, lane, eff_ws);
  assign busy    = (st != SEQ_IDLE);

  // one port at a time (R8)
  assert_one_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  // read held until valid (R8)
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  // write held until acknowledged (R8)
  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  // done is a single-cycle pulse (R9)
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |=> !block_done);

  // done follows an acknowledged write (R9)
  assert_done_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |-> $past(wr_req && wr_ack));

  // no traffic while disarmed (R11)
  assert_no_read_disarmed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> $past(armed));

  // a packet load only lands when idle (R2)
  assert_load_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && busy) |=> $stable(snap_mode));

endmodule

// File: tb/dma_chan_seq_test.sv
`timescale 1ns/1ps
module dma_chan_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [31:0] cfg_src_base = '0, cfg_dst_base = '0;
  logic [12:0] cfg_elem_cnt = '0, cfg_frame_cnt = '0;
  logic [15:0] cfg_src_elem_step = '0, cfg_src_frame_step = '0;
  logic [15:0] cfg_dst_elem_step = '0, cfg_dst_frame_step = '0;
  logic [1:0]  cfg_rd_size = '0, cfg_wr_size = '0;
  logic        cfg_frame_mode = 1'b0, cfg_src_offset_mode = 1'b0;
  logic        cfg_dst_offset_mode = 1'b0, cfg_auto_reload = 1'b0;
  logic        chan_en = 1'b0, hw_sel = 1'b0, hw_req = 1'b0, sw_req = 1'b0;
  logic        rd_req, wr_req, busy, block_done;
  logic [31:0] rd_addr, wr_addr;
  logic [1:0]  rd_size, wr_size;
  logic        rd_valid = 1'b0, wr_ack = 1'b0;
  logic [63:0] rd_data = '0;
  logic [63:0] wr_data;

  always #4 clk = ~clk;

  dma_chan_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
    .cfg_elem_cnt(cfg_elem_cnt), .cfg_frame_cnt(cfg_frame_cnt),
    .cfg_src_elem_step(cfg_src_elem_step), .cfg_src_frame_step(cfg_src_frame_step),
    .cfg_dst_elem_step(cfg_dst_elem_step), .cfg_dst_frame_step(cfg_dst_frame_step),
    .cfg_rd_size(cfg_rd_size), .cfg_wr_size(cfg_wr_size),
    .cfg_frame_mode(cfg_frame_mode), .cfg_src_offset_mode(cfg_src_offset_mode),
    .cfg_dst_offset_mode(cfg_dst_offset_mode), .cfg_auto_reload(cfg_auto_reload),
    .chan_en(chan_en), .hw_sel(hw_sel), .hw_req(hw_req), .sw_req(sw_req),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size), .rd_valid(rd_valid),
    .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size),
    .wr_data(wr_data), .wr_ack(wr_ack), .busy(busy), .block_done(block_done)
  );

  int n_chk = 0, n_fail = 0;
  int wi = 0, ri = 0, n_w = 1, n_r = 1;
  int wcount = 0, rcount = 0, done_seen = 0;
  int wdly = 0, rdly = 0;
  bit pend_done = 1'b0;
  logic [31:0] exp_wa [0:255];
  logic [63:0] exp_wd [0:255];
  logic [31:0] exp_ra [0:255];
  logic [1:0]  exp_ws, exp_rs;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // memory contents as seen through a read of sz
  function automatic logic [63:0] mem_val(logic [31:0] a, logic [1:0] sz);
    logic [63:0] v;
    v = {a ^ 32'hC3A5_96E1, (a * 32'h0100_0193) + 32'h0000_1357};
    if (sz == 2'd0) v = v & 64'hFF;
    else if (sz == 2'd1) v = v & 64'hFFFF;
    else if (sz == 2'd2) v = v & 64'hFFFF_FFFF;
    return v;
  endfunction

  function automatic logic [63:0] lane_of(logic [63:0] v, int k, int wbytes);
    int wb;
    logic [63:0] r;
    wb = wbytes * 8;
    r = v >> (k * wb);
    if (wb < 64) r = r & ((64'd1 << wb) - 64'd1);
    return r;
  endfunction

  function automatic logic [31:0] sx(logic [15:0] o);
    return {{16{o[15]}}, o};
  endfunction

  // expected trace of one block, from the requirements
  task automatic build();
    int ne, nf, lanes;
    logic [31:0] s, d;
    logic [63:0] v;
    ne = (cfg_elem_cnt == 0) ? 1 : int'(cfg_elem_cnt);
    nf = (cfg_frame_cnt == 0) ? 1 : int'(cfg_frame_cnt);
    exp_rs = cfg_rd_size;
    exp_ws = (cfg_wr_size > cfg_rd_size) ? cfg_rd_size : cfg_wr_size;
    lanes = 1 << (exp_rs - exp_ws);
    s = cfg_src_base;
    d = cfg_dst_base;
    n_w = 0;
    n_r = 0;
    for (int f = 0; f < nf; f++) begin
      for (int e = 0; e < ne; e++) begin
        exp_ra[n_r] = s;
        n_r++;
        v = mem_val(s, exp_rs);
        for (int k = 0; k < lanes; k++) begin
          exp_wa[n_w] = d;
          exp_wd[n_w] = lane_of(v, k, 1 << exp_ws);
          n_w++;
          if (cfg_dst_offset_mode)
            d = d + ((e == ne - 1 && k == lanes - 1) ? sx(cfg_dst_frame_step) : sx(cfg_dst_elem_step));
        end
        if (cfg_src_offset_mode)
          s = s + ((e == ne - 1) ? sx(cfg_src_frame_step) : sx(cfg_src_elem_step));
      end
    end
  endtask

  // read responder
  always @(negedge clk) begin
    if (rd_valid) begin
      rd_valid = 1'b0;
      rd_data  = '0;
    end else if (rd_req) begin
      if (rdly != 0) rdly--;
      else begin
        chk(rd_addr == exp_ra[ri], "R7 read address", 64'(rd_addr), 64'(exp_ra[ri]));
        chk(rd_size == exp_rs, "R6 read size", 64'(rd_size), 64'(exp_rs));
        rd_data  = mem_val(rd_addr, rd_size);
        rd_valid = 1'b1;
        ri++;
        if (ri == n_r) ri = 0;
        rcount++;
        rdly = $urandom_range(0, 2);
      end
    end
  end

  // write responder and done timing
  always @(negedge clk) begin
    if (pend_done || block_done) begin
      chk(block_done == pend_done, "R9 done one cycle after last write", 64'(block_done), 64'(pend_done));
      if (block_done) done_seen++;
      pend_done = 1'b0;
    end
    if (wr_ack) wr_ack = 1'b0;
    else if (wr_req) begin
      if (wdly != 0) wdly--;
      else begin
        chk(wr_addr == exp_wa[wi], "R7 write address", 64'(wr_addr), 64'(exp_wa[wi]));
        chk(wr_data == exp_wd[wi], "R6 write lane data", wr_data, exp_wd[wi]);
        chk(wr_size == exp_ws, "R6 write size", 64'(wr_size), 64'(exp_ws));
        wi++;
        if (wi == n_w) begin
          wi = 0;
          pend_done = 1'b1;
        end
        wcount++;
        wr_ack = 1'b1;
        wdly = $urandom_range(0, 2);
      end
    end
  end

  task automatic set_cfg(input logic [31:0] src, input logic [31:0] dst,
                         input int ec, input int fc,
                         input logic [15:0] seo, input logic [15:0] sfo,
                         input logic [15:0] deo, input logic [15:0] dfo,
                         input logic [1:0] rs, input logic [1:0] ws,
                         input bit fm, input bit sm, input bit dm, input bit ar);
    @(negedge clk);
    cfg_src_base = src; cfg_dst_base = dst;
    cfg_elem_cnt = 13'(ec); cfg_frame_cnt = 13'(fc);
    cfg_src_elem_step = seo; cfg_src_frame_step = sfo;
    cfg_dst_elem_step = deo; cfg_dst_frame_step = dfo;
    cfg_rd_size = rs; cfg_wr_size = ws;
    cfg_frame_mode = fm; cfg_src_offset_mode = sm;
    cfg_dst_offset_mode = dm; cfg_auto_reload = ar;
    build();
    wi = 0; ri = 0; wcount = 0; rcount = 0; done_seen = 0;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic pulse(input bit use_sw);
    @(negedge clk);
    if (use_sw) sw_req = 1'b1; else hw_req = 1'b1;
    @(negedge clk);
    sw_req = 1'b0;
    hw_req = 1'b0;
  endtask

  task automatic wait_idle();
    int guard;
    guard = 0;
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_ignored(input string what);
    int rc;
    rc = rcount;
    repeat (10) @(negedge clk);
    chk(busy == 1'b0 && rcount == rc, what, 64'(rcount - rc), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(rd_req == 0 && wr_req == 0, "R1 ports quiet after reset", {62'd0, rd_req, wr_req}, 64'd0);
    chk(busy == 0 && block_done == 0, "R1 busy and done low after reset", {62'd0, busy, block_done}, 64'd0);
    chan_en = 1'b1; hw_sel = 1'b0;
    pulse(1'b1);
    expect_ignored("R1 trigger before any packet ignored");

    // R4 R5 R6 R7: frame mode, 64-bit reads into 16-bit writes every other slot
    hw_sel = 1'b1;
    set_cfg(32'h1000, 32'h8000, 4, 2, 16'd8, 16'h0020, 16'd4, 16'h0040,
            2'd3, 2'd1, 1, 1, 1, 0);
    pulse(1'b0); wait_idle();
    chk(wcount == 16, "R4 one trigger moves one frame", 64'(wcount), 64'd16);
    chk(done_seen == 0, "R9 no done mid-block", 64'(done_seen), 64'd0);
    pulse(1'b0); wait_idle();
    chk(wcount == 32, "R5 block size elements times frames", 64'(wcount), 64'd32);
    chk(done_seen == 1, "R9 done at block end", 64'(done_seen), 64'd1);
    pulse(1'b0);
    expect_ignored("R11 disarmed after block without reload");

    // R4 R11: element mode, software trigger, auto reload, negative offsets
    hw_sel = 1'b0;
    set_cfg(32'h2000, 32'h9000, 3, 2, 16'd4, 16'hFFF0, 16'd1, 16'hFFFC,
            2'd2, 2'd0, 0, 1, 1, 1);
    pulse(1'b1); wait_idle();
    chk(wcount == 4, "R4 one trigger moves one element", 64'(wcount), 64'd4);
    for (int t = 0; t < 5; t++) begin pulse(1'b1); wait_idle(); end
    chk(done_seen == 1, "R11 first block done", 64'(done_seen), 64'd1);
    for (int t = 0; t < 6; t++) begin pulse(1'b1); wait_idle(); end
    chk(done_seen == 2 && wcount == 48, "R11 reload repeats the block", 64'(wcount), 64'd48);

    // R10 held trigger
    hw_sel = 1'b1;
    set_cfg(32'h3000, 32'hA000, 3, 3, 16'd2, 16'd2, 16'd2, 16'd2,
            2'd1, 2'd1, 1, 1, 1, 0);
    pulse(1'b0);
    repeat (2) @(negedge clk);
    pulse(1'b0);
    wait_idle();
    chk(wcount == 6, "R10 held trigger runs second frame", 64'(wcount), 64'd6);
    pulse(1'b0); wait_idle();
    chk(done_seen == 1 && wcount == 9, "R10 block completes after held trigger", 64'(wcount), 64'd9);

    // R3 trigger selection
    set_cfg(32'h3000, 32'hA000, 1, 2, 16'd2, 16'd2, 16'd2, 16'd2,
            2'd1, 2'd1, 1, 1, 1, 0);
    chan_en = 1'b0;
    pulse(1'b0);
    expect_ignored("R3 disabled channel ignores hardware request");
    chan_en = 1'b1; hw_sel = 1'b1;
    pulse(1'b1);
    expect_ignored("R3 software pulse ignored in hardware selection");
    hw_sel = 1'b0;
    pulse(1'b0);
    expect_ignored("R3 hardware pulse ignored in software selection");
    pulse(1'b1); wait_idle();
    chk(wcount == 1, "R3 software trigger accepted", 64'(wcount), 64'd1);
    pulse(1'b1); wait_idle();

    // R6 R7: fixed addressing, write size above read size
    hw_sel = 1'b1;
    set_cfg(32'h4000, 32'hB000, 2, 2, 16'd8, 16'd8, 16'd8, 16'd8,
            2'd1, 2'd3, 1, 0, 0, 0);
    pulse(1'b0); wait_idle();
    pulse(1'b0); wait_idle();
    chk(wcount == 4 && done_seen == 1, "R6 wide write clamps to read size", 64'(wcount), 64'd4);

    // R2 load during transfer ignored
    set_cfg(32'h5000, 32'hC000, 6, 1, 16'd8, 16'd8, 16'd2, 16'd2,
            2'd3, 2'd1, 1, 1, 1, 0);
    pulse(1'b0);
    @(negedge clk);
    cfg_src_base = 32'h7700; cfg_dst_base = 32'h7800;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    wait_idle();
    chk(wcount == 24 && done_seen == 1, "R2 load while busy leaves block intact", 64'(wcount), 64'd24);

    // R5 zero counts treated as one
    set_cfg(32'h6000, 32'hD000, 0, 0, 16'd8, 16'd8, 16'd2, 16'd2,
            2'd2, 2'd1, 1, 1, 1, 0);
    pulse(1'b0); wait_idle();
    chk(wcount == 2 && done_seen == 1, "R5 zero counts give one element", 64'(wcount), 64'd2);

    // random packets
    for (int it = 0; it < 20; it++) begin
      bit fm, sw;
      int ec, fc, trig_n;
      fm = 1'($urandom_range(0, 1));
      sw = 1'($urandom_range(0, 1));
      ec = $urandom_range(1, 4);
      fc = $urandom_range(1, 3);
      hw_sel = ~sw;
      set_cfg(32'h10000 + 32'($urandom_range(0, 255)) * 8, 32'h20000 + 32'($urandom_range(0, 255)) * 8,
              ec, fc,
              16'($urandom_range(0, 128) - 64), 16'($urandom_range(0, 128) - 64),
              16'($urandom_range(0, 128) - 64), 16'($urandom_range(0, 128) - 64),
              2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
              fm, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      trig_n = fm ? fc : ec * fc;
      for (int t = 0; t < trig_n; t++) begin pulse(sw); wait_idle(); end
      chk(wcount == n_w, "R5 random block write count", 64'(wcount), 64'(n_w));
      chk(done_seen == 1, "R9 random block done once", 64'(done_seen), 64'd1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule